// File: doc/BRIEF.md
# Radio Interrupt Aggregator with Mode Gating

This block gathers event pulses from three groups of radio interrupt sources (transmit, receive and system) into sticky per-group status registers. It combines them into one shared interrupt line. Firmware reaches the block through a simple register read/write port. Through that port it sets one enable bit per source, picks the polarity and drive style of the line, and reads status, which clears on read.

The present radio mode gates whole groups off the line. In transmit mode the receive group cannot raise the line. In receive mode the transmit group cannot raise it. In idle, neither group is blocked, and the system group is never gated by mode. Gating acts only on the line. The stored enable bits are left untouched, so switching modes costs firmware no rewrite. Status bits record every event whether or not the source is enabled, which lets firmware poll status without using the line.

The register port is plain control: a write or read strobe lasts one cycle and has no back-pressure. Read data appears on the cycle after the read strobe.

Top module: `irq_aggregator`

## Requirements
- R1: A one-cycle event pulse on any source bit (`tx_evt`, `rx_evt`, `sys_evt`) sets the matching status bit at that clock edge, whatever the enable and mode settings.
- R2: A read strobe to a status address (4 = transmit, 5 = receive, 6 = system) returns the status, zero-extended, on `reg_rdata` in the next cycle and clears it. An event bit arriving in the same cycle as the read is not shown by that read and stays set for the next read.
- R3: Enable registers sit at address 0 (transmit), 1 (receive) and 2 (system), with bit i enabling source i. Each is written on its own and reads back what was written, and a write to one leaves the others unchanged.
- R4: Mode is encoded on `mode` as 0 = idle, 1 = transmit, 2 = receive, 3 = idle. Transmit mode blocks the receive group from the line, receive mode blocks the transmit group, idle blocks neither, and the system group is never blocked.
- R5: Changing `mode` never changes the contents of any enable register.
- R6: The line is active when at least one source has status, enable and mode gate all true. The line is registered: a status bit set at edge k shows on the line after edge k+1.
- R7: Configuration is at address 3, with bit 0 = active-low and bit 1 = open-drain. In push-pull, `irq_pin` is the active level (1 when active-high, 0 when active-low) while the line is active, and the opposite level otherwise.
- R8: In open-drain, `irq_oe` is 1 only while the line is active, and `irq_pin` then holds the active level. In push-pull, `irq_oe` is always 1.
- R9: After reset, all status, enable and configuration bits are 0, `irq_pin` is 0 and `irq_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Radio mode: 0 idle, 1 transmit, 2 receive, 3 idle |
| tx_evt | input | GRP_W | Transmit-group event pulses |
| rx_evt | input | GRP_W | Receive-group event pulses |
| sys_evt | input | GRP_W | System-group event pulses |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid the cycle after `reg_rd` |
| irq_pin | output | 1 | Interrupt line level |
| irq_oe | output | 1 | Drive enable for the line (0 = high-impedance) |

## Verification
A table of vectors drives each mode with events that are enabled and disabled in each group. This tells mode gating of the transmit and receive groups apart from enable masking, and shows that system sources pass in every mode. The same vectors walk the four configuration settings, which separates polarity inversion from open-drain release. Reading status after each vector shows that capture does not depend on the enable bits. Directed tests cover a read that collides with an event in the same cycle, the one-cycle register delay on the line, mode switching against stored enables, and the reset state.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int ADDR_W = 3;
  localparam int N_GRP  = 3;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_TX    = 2'd1,
    MODE_RX    = 2'd2,
    MODE_IDLE2 = 2'd3
  } radio_mode_e;

  localparam int GRP_TX  = 0;
  localparam int GRP_RX  = 1;
  localparam int GRP_SYS = 2;

  localparam logic [ADDR_W-1:0] A_EN_BASE = 3'd0;
  localparam logic [ADDR_W-1:0] A_CFG     = 3'd3;
  localparam logic [ADDR_W-1:0] A_ST_BASE = 3'd4;

  localparam int CFG_ACT_LOW = 0;
  localparam int CFG_OPEN_DR = 1;
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         rd_clr,
  output logic [W-1:0] stat
);
  logic [W-1:0] stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      stat_q <= '0;
    else if (rd_clr) stat_q <= evt;
    else             stat_q <= stat_q | evt;
  end

  assign stat = stat_q;

  // R1: every event bit lands in status at the edge it is sampled
  a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((stat & $past(evt)) == $past(evt)));

  // R2: a clearing read leaves only the colliding events
  a_r2_clear_keep: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr |=> (stat == $past(evt)));
endmodule

// File: rtl/irq_mode_gate.sv
module irq_mode_gate
  import irq_agg_pkg::*;
#(
  parameter int W = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             mode,
  input  logic [N_GRP-1:0][W-1:0] stat,
  input  logic [N_GRP-1:0][W-1:0] en,
  output logic                   pending
);
  logic [N_GRP-1:0] grp_ok;
  logic [N_GRP-1:0] grp_hit;

  always_comb begin
    grp_ok          = '1;
    grp_ok[GRP_RX]  = (mode != MODE_TX);
    grp_ok[GRP_TX]  = (mode != MODE_RX);
    grp_ok[GRP_SYS] = 1'b1;
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_hit
    assign grp_hit[g] = grp_ok[g] & |(stat[g] & en[g]);
  end

  assign pending = |grp_hit;

  // R4: in transmit mode only transmit and system sources may raise the line
  a_r4_tx_blocks_rx: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MODE_TX) && ((stat[GRP_TX] & en[GRP_TX]) == '0)
      && ((stat[GRP_SYS] & en[GRP_SYS]) == '0)) |-> !pending);

  // R4: in receive mode only receive and system sources may raise the line
  a_r4_rx_blocks_tx: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MODE_RX) && ((stat[GRP_RX] & en[GRP_RX]) == '0)
      && ((stat[GRP_SYS] & en[GRP_SYS]) == '0)) |-> !pending);

  // R4: enabled system status always raises the line
  a_r4_sys_free: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat[GRP_SYS] & en[GRP_SYS]) != '0) |-> pending);
endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv (
  input  logic clk,
  input  logic rst_n,
  input  logic pending,
  input  logic act_low,
  input  logic open_dr,
  output logic pin,
  output logic oe
);
  logic pin_d, oe_d;
  logic pin_q, oe_q;

  always_comb begin
    if (open_dr) begin
      oe_d  = pending;
      pin_d = ~act_low;
    end else begin
      oe_d  = 1'b1;
      pin_d = pending ^ act_low;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
      oe_q  <= 1'b1;
    end else begin
      pin_q <= pin_d;
      oe_q  <= oe_d;
    end
  end

  assign pin = pin_q;
  assign oe  = oe_q;

  // R7: push-pull level follows pending and polarity one edge later
  a_r7_polarity: assert property (@(posedge clk) disable iff (!rst_n)
    !open_dr |=> (pin == ($past(pending) ^ $past(act_low))));

  // R8: open-drain releases the line while nothing is pending
  a_r8_od_release: assert property (@(posedge clk) disable iff (!rst_n)
    (open_dr && !pending) |=> !oe);

  // R8: push-pull always drives
  a_r8_pp_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !open_dr |=> oe);
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int GRP_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [GRP_W-1:0]  tx_evt,
  input  logic [GRP_W-1:0]  rx_evt,
  input  logic [GRP_W-1:0]  sys_evt,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_pin,
  output logic              irq_oe
);
  localparam int PAD_W = DATA_W - GRP_W;

  logic [N_GRP-1:0][GRP_W-1:0] evt;
  logic [N_GRP-1:0][GRP_W-1:0] stat;
  logic [N_GRP-1:0][GRP_W-1:0] en_q;
  logic [N_GRP-1:0]            rd_clr;
  logic [1:0]                  cfg_q;
  logic                        pending;
  logic [DATA_W-1:0]           rdata_q;
  logic [DATA_W-1:0]           rdata_d;

  assign evt[GRP_TX]  = tx_evt;
  assign evt[GRP_RX]  = rx_evt;
  assign evt[GRP_SYS] = sys_evt;

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    localparam logic [ADDR_W-1:0] EN_A = A_EN_BASE + ADDR_W'(g);
    localparam logic [ADDR_W-1:0] ST_A = A_ST_BASE + ADDR_W'(g);

    assign rd_clr[g] = reg_rd && (reg_addr == ST_A);

    irq_status_bank #(.W(GRP_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt    (evt[g]),
      .rd_clr (rd_clr[g]),
      .stat   (stat[g])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          en_q[g] <= '0;
      else if (reg_wr && reg_addr == EN_A) en_q[g] <= reg_wdata[GRP_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           cfg_q <= '0;
    else if (reg_wr && reg_addr == A_CFG) cfg_q <= reg_wdata[1:0];
  end

  always_comb begin
    rdata_d = '0;
    for (int g = 0; g < N_GRP; g++) begin
      if (reg_addr == A_EN_BASE + ADDR_W'(g)) rdata_d = {{PAD_W{1'b0}}, en_q[g]};
      if (reg_addr == A_ST_BASE + ADDR_W'(g)) rdata_d = {{PAD_W{1'b0}}, stat[g]};
    end
    if (reg_addr == A_CFG) rdata_d = {{(DATA_W-2){1'b0}}, cfg_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (reg_rd) rdata_q <= rdata_d;
  end

  assign reg_rdata = rdata_q;

  irq_mode_gate #(.W(GRP_W)) u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .stat    (stat),
    .en      (en_q),
    .pending (pending)
  );

  irq_pin_drv u_drv (
    .clk     (clk),
    .rst_n   (rst_n),
    .pending (pending),
    .act_low (cfg_q[CFG_ACT_LOW]),
    .open_dr (cfg_q[CFG_OPEN_DR]),
    .pin     (irq_pin),
    .oe      (irq_oe)
  );

  // R5: enable contents move only on a register write, never on a mode change
  a_r5_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(en_q));

  // R3: a write reaches only the addressed enable register
  a_r3_en_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr != A_EN_BASE) |=> $stable(en_q[GRP_TX]));

  // R2: status reads return the status seen at the read edge
  a_r2_read_data: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_ST_BASE) |=>
      (reg_rdata == {{PAD_W{1'b0}}, $past(stat[GRP_TX])}));
endmodule

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;
  localparam int CLK_P  = 10;
  localparam int GRP_W  = 6;
  localparam int DATA_W = 8;
  localparam int NV     = 12;

  // {mode, cfg, tx_en, rx_en, sys_en, tx_ev, rx_ev, sys_ev}
  localparam logic [39:0] VEC [NV] = '{
    {2'd0, 2'd0, 6'h01, 6'h00, 6'h00, 6'h01, 6'h00, 6'h00},
    {2'd1, 2'd0, 6'h00, 6'h02, 6'h00, 6'h00, 6'h02, 6'h00},
    {2'd2, 2'd0, 6'h00, 6'h02, 6'h00, 6'h00, 6'h02, 6'h00},
    {2'd2, 2'd0, 6'h04, 6'h00, 6'h00, 6'h04, 6'h00, 6'h00},
    {2'd1, 2'd0, 6'h00, 6'h00, 6'h08, 6'h00, 6'h00, 6'h08},
    {2'd2, 2'd0, 6'h00, 6'h00, 6'h00, 6'h00, 6'h00, 6'h08},
    {2'd0, 2'd1, 6'h00, 6'h10, 6'h00, 6'h00, 6'h10, 6'h00},
    {2'd0, 2'd1, 6'h3f, 6'h3f, 6'h3f, 6'h00, 6'h00, 6'h00},
    {2'd0, 2'd2, 6'h01, 6'h00, 6'h00, 6'h01, 6'h00, 6'h00},
    {2'd0, 2'd2, 6'h01, 6'h00, 6'h00, 6'h02, 6'h00, 6'h00},
    {2'd1, 2'd3, 6'h3f, 6'h00, 6'h00, 6'h20, 6'h15, 6'h00},
    {2'd3, 2'd0, 6'h00, 6'h01, 6'h00, 6'h00, 6'h01, 6'h00}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        mode = '0;
  logic [GRP_W-1:0]  tx_evt = '0, rx_evt = '0, sys_evt = '0;
  logic              reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]        reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic              irq_pin, irq_oe;

  int n_chk = 0;
  int n_err = 0;
  logic [DATA_W-1:0] rd;

  always #(CLK_P/2) clk = ~clk;

  irq_aggregator #(.GRP_W(GRP_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .tx_evt(tx_evt), .rx_evt(rx_evt), .sys_evt(sys_evt),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_pin(irq_pin), .irq_oe(irq_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DATA_W-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rdreg(input logic [2:0] a, output logic [DATA_W-1:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R9: reset state
    chk("R9 pin", irq_pin, 1'b0);
    chk("R9 oe", irq_oe, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 7; a++) begin
      rdreg(3'(a), rd);
      chk("R9 reg", rd, 0);
    end

    // table walk: R1 R4 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      logic [1:0] m, c;
      logic [5:0] te, re, se, tv, rv, sv;
      logic act, exp_oe, exp_pin;
      {m, c, te, re, se, tv, rv, sv} = VEC[v];
      wr(3'd0, {2'b0, te}); wr(3'd1, {2'b0, re}); wr(3'd2, {2'b0, se});
      wr(3'd3, {6'b0, c});
      mode = m;
      rdreg(3'd4, rd); rdreg(3'd5, rd); rdreg(3'd6, rd);
      @(negedge clk);
      tx_evt = tv; rx_evt = rv; sys_evt = sv;
      @(negedge clk);
      tx_evt = '0; rx_evt = '0; sys_evt = '0;
      @(negedge clk);
      act = (|(tv & te) && m != 2'd2) || (|(rv & re) && m != 2'd1) || |(sv & se);
      exp_oe  = c[1] ? act : 1'b1;
      exp_pin = c[1] ? ~c[0] : (act ^ c[0]);
      chk("R8 oe", irq_oe, exp_oe);
      if (exp_oe) chk("R4/R6/R7 pin", irq_pin, exp_pin);
      rdreg(3'd4, rd); chk("R1 tx status", rd, {2'b0, tv});
      rdreg(3'd5, rd); chk("R1 rx status", rd, {2'b0, rv});
      rdreg(3'd6, rd); chk("R1 sys status", rd, {2'b0, sv});
    end

    // R6: one-register delay on the line
    wr(3'd3, 8'h00); mode = 2'd0; wr(3'd2, 8'h01);
    @(negedge clk);
    sys_evt = 6'h01;
    @(negedge clk);
    sys_evt = '0;
    chk("R6 not yet", irq_pin, 1'b0);
    @(negedge clk);
    chk("R6 asserted", irq_pin, 1'b1);
    rdreg(3'd6, rd);
    @(negedge clk);
    chk("R6 cleared by read", irq_pin, 1'b0);

    // R2: collision of read and event
    tx_evt = 6'h02; reg_rd = 1'b1; reg_addr = 3'd4;
    @(negedge clk);
    tx_evt = '0; reg_rd = 1'b0;
    chk("R2 collide read", reg_rdata, 8'h00);
    rdreg(3'd4, rd); chk("R2 kept", rd, 8'h02);
    rdreg(3'd4, rd); chk("R2 clear", rd, 8'h00);

    // R3: independent enable writes
    wr(3'd0, 8'h2a); wr(3'd1, 8'h15); wr(3'd2, 8'h33);
    rdreg(3'd0, rd); chk("R3 tx en", rd, 8'h2a);
    rdreg(3'd1, rd); chk("R3 rx en", rd, 8'h15);
    rdreg(3'd2, rd); chk("R3 sys en", rd, 8'h33);

    // R5: mode switching keeps enables
    for (int m = 0; m < 4; m++) begin
      mode = 2'(m);
      @(negedge clk); @(negedge clk);
      rdreg(3'd0, rd); chk("R5 tx en", rd, 8'h2a);
      rdreg(3'd1, rd); chk("R5 rx en", rd, 8'h15);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule